// File: doc/BRIEF.md
# Low-Power Wait and Stop Sequencer

This block moves a processor core between normal running and two low-power states. Decoded strobes for the wait and stop instructions request entry. The block then drives a core clock enable and a peripheral clock enable. On entry it emits a one-cycle pulse that clears the core's interrupt mask, so that a later interrupt can be taken. In wait state only the core clock is gated. In stop state the peripheral clock is gated as well.

The core leaves either low-power state on an enabled interrupt, on a debug break, or on reset. An interrupt wake issues a stack-start pulse in the cycle after the one in which the interrupt was seen. A break wake sets a sticky status flag, which software clears by writing a one. A watchdog-active output tells the watchdog whether it keeps counting. It stays high in wait unless the watchdog-disable option is set.

Top module: `lpm_sequencer`

## Requirements
- R1: With the sequencer running, a stop or wait strobe sampled at a clock edge enters stop or wait state at that edge. In the next cycle `imask_clr` is high for exactly one cycle. When both strobes are high together, stop wins.
- R2: In wait state `core_clk_en` is 0 and `periph_clk_en` is 1.
- R3: In stop state both `core_clk_en` and `periph_clk_en` are 0.
- R4: In either low-power state, an interrupt source i with `irq_pend[i]`=1 and `irq_en[i]`=1 at an edge returns the sequencer to running at that edge. In the next cycle `core_clk_en` and `periph_clk_en` are 1 and `stack_start` is high for exactly one cycle. A pending source with `irq_en[i]`=0 does not wake the core.
- R5: Synchronous reset returns the sequencer to running from any state. After reset, `core_clk_en`=1, `periph_clk_en`=1, `imask_clr`=0, `stack_start`=0 and `brk_lp_flag`=0.
- R6: A `break_req` seen in a low-power state returns the sequencer to running and sets `brk_lp_flag` in the next cycle. A break seen while running leaves the flag unchanged. When a break and an enabled interrupt arrive at the same edge, the break wins and no `stack_start` is issued.
- R7: `brk_lp_flag` holds until `brk_flag_clr`=1 (a write of one) or reset. If it is set and cleared at the same edge, setting wins.
- R8: `wdog_active` equals the inverse of `wdog_disable` while running and in wait state. It is 0 in stop state.
- R9: A wait or stop strobe in a low-power state, with no wake condition present, is ignored. No `imask_clr` pulse is issued and the clock enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_strobe | input | 1 | Decoded wait instruction |
| stop_strobe | input | 1 | Decoded stop instruction |
| irq_pend | input | NUM_SRC | Per-source pending interrupt |
| irq_en | input | NUM_SRC | Per-source interrupt enable at the peripheral |
| break_req | input | 1 | Debug break request |
| brk_flag_clr | input | 1 | Write of one to the break status flag |
| wdog_disable | input | 1 | Watchdog-disable option |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| imask_clr | output | 1 | Pulse clearing the interrupt mask |
| stack_start | output | 1 | Pulse starting interrupt stacking |
| brk_lp_flag | output | 1 | Sticky break-during-low-power flag |
| wdog_active | output | 1 | Watchdog keeps running |

## Verification
The bench sweeps every enable pattern against every single pending source, in both wait and stop. A design that ignores the per-source enable would wake on masked sources, and one that checks the wrong bit would fail for specific patterns. It drives a break together with an interrupt to catch a stray stack-start pulse. It also drives a set and a clear of the flag at the same edge, where a design that lets the clear win would lose the status. Repeated strobes in a low-power state are applied to expose a design that pulses the mask clear again or moves between wait and stop.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LPM_RUN  = 2'd0,
        LPM_WAIT = 2'd1,
        LPM_STOP = 2'd2
    } lpm_state_e;

    typedef struct packed {
        logic irq;
        logic brk;
    } wake_t;

    typedef struct packed {
        logic core_en;
        logic periph_en;
    } clk_en_t;

    function automatic clk_en_t clk_enables(lpm_state_e s);
        clk_en_t c;
        c.core_en   = (s == LPM_RUN);
        c.periph_en = (s != LPM_STOP);
        return c;
    endfunction

    function automatic logic is_low_power(lpm_state_e s);
        return s != LPM_RUN;
    endfunction

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect
    import lpm_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               break_req,
    output wake_t              wake
);
    logic [NUM_SRC-1:0] live;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign live[i] = irq_pend[i] & irq_en[i];
    end

    assign wake.irq = |live;
    assign wake.brk = break_req;
endmodule

// File: rtl/lpm_state_ctl.sv
module lpm_state_ctl
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wait_strobe,
    input  logic       stop_strobe,
    input  wake_t      wake,
    output lpm_state_e state,
    output logic       imask_clr,
    output logic       stack_start
);
    lpm_state_e state_n;
    logic       imask_n;
    logic       stack_n;

    always_comb begin
        state_n = state;
        imask_n = 1'b0;
        stack_n = 1'b0;
        unique case (state)
            LPM_RUN: begin
                if (stop_strobe) begin
                    state_n = LPM_STOP;
                    imask_n = 1'b1;
                end else if (wait_strobe) begin
                    state_n = LPM_WAIT;
                    imask_n = 1'b1;
                end
            end
            LPM_WAIT, LPM_STOP: begin
                if (wake.brk) begin
                    state_n = LPM_RUN;
                end else if (wake.irq) begin
                    state_n = LPM_RUN;
                    stack_n = 1'b1;
                end
            end
            default: state_n = LPM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= LPM_RUN;
            imask_clr   <= 1'b0;
            stack_start <= 1'b0;
        end else begin
            state       <= state_n;
            imask_clr   <= imask_n;
            stack_start <= stack_n;
        end
    end
endmodule

// File: rtl/lpm_status.sv
module lpm_status
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lpm_state_e state,
    input  logic       break_req,
    input  logic       brk_flag_clr,
    input  logic       wdog_disable,
    output logic       brk_lp_flag,
    output logic       wdog_active
);
    logic set_flag;

    assign set_flag = is_low_power(state) && break_req;

    always_ff @(posedge clk) begin
        if (rst)
            brk_lp_flag <= 1'b0;
        else if (set_flag)
            brk_lp_flag <= 1'b1;
        else if (brk_flag_clr)
            brk_lp_flag <= 1'b0;
    end

    assign wdog_active = !wdog_disable && (state != LPM_STOP);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wait_strobe,
    input  logic               stop_strobe,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               break_req,
    input  logic               brk_flag_clr,
    input  logic               wdog_disable,
    output logic               core_clk_en,
    output logic               periph_clk_en,
    output logic               imask_clr,
    output logic               stack_start,
    output logic               brk_lp_flag,
    output logic               wdog_active
);
    wake_t      wake;
    lpm_state_e state;
    clk_en_t    en;

    lpm_wake_detect #(.NUM_SRC(NUM_SRC)) u_wake (
        .irq_pend  (irq_pend),
        .irq_en    (irq_en),
        .break_req (break_req),
        .wake      (wake)
    );

    lpm_state_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .wait_strobe (wait_strobe),
        .stop_strobe (stop_strobe),
        .wake        (wake),
        .state       (state),
        .imask_clr   (imask_clr),
        .stack_start (stack_start)
    );

    lpm_status u_stat (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .break_req    (break_req),
        .brk_flag_clr (brk_flag_clr),
        .wdog_disable (wdog_disable),
        .brk_lp_flag  (brk_lp_flag),
        .wdog_active  (wdog_active)
    );

    assign en            = clk_enables(state);
    assign core_clk_en   = en.core_en;
    assign periph_clk_en = en.periph_en;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               wait_strobe,
    input logic               stop_strobe,
    input logic [NUM_SRC-1:0] irq_pend,
    input logic [NUM_SRC-1:0] irq_en,
    input logic               break_req,
    input logic               brk_flag_clr,
    input logic               wdog_disable,
    input logic               core_clk_en,
    input logic               periph_clk_en,
    input logic               imask_clr,
    input logic               stack_start,
    input logic               brk_lp_flag,
    input logic               wdog_active
);
    logic any_wake;
    assign any_wake = (|(irq_pend & irq_en)) || break_req;

    p_enter_imask_r1: assert property (@(posedge clk) disable iff (rst)
        core_clk_en && (wait_strobe || stop_strobe) |=> imask_clr && !core_clk_en);

    p_wait_clocks_r2: assert property (@(posedge clk) disable iff (rst)
        core_clk_en && wait_strobe && !stop_strobe |=> periph_clk_en);

    p_stop_clocks_r3: assert property (@(posedge clk) disable iff (rst)
        core_clk_en && stop_strobe |=> !periph_clk_en);

    p_irq_stack_r4: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en && (|(irq_pend & irq_en)) && !break_req |=> stack_start && core_clk_en);

    p_brk_flag_r6: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en && break_req |=> brk_lp_flag && core_clk_en && !stack_start);

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        brk_lp_flag && !brk_flag_clr |=> brk_lp_flag);

    p_wdog_wait_r8: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en && periph_clk_en && !wdog_disable |-> wdog_active);

    p_ignore_req_r9: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en && !any_wake |=> !imask_clr && $stable(periph_clk_en) && !core_clk_en);
endmodule

bind lpm_sequencer lpm_sequencer_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .wait_strobe   (wait_strobe),
    .stop_strobe   (stop_strobe),
    .irq_pend      (irq_pend),
    .irq_en        (irq_en),
    .break_req     (break_req),
    .brk_flag_clr  (brk_flag_clr),
    .wdog_disable  (wdog_disable),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .imask_clr     (imask_clr),
    .stack_start   (stack_start),
    .brk_lp_flag   (brk_lp_flag),
    .wdog_active   (wdog_active)
);

// File: tb/lpm_sequencer_tb_top.sv
`timescale 1ns/1ps
module lpm_sequencer_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         wait_strobe, stop_strobe, break_req, brk_flag_clr, wdog_disable;
    logic [N-1:0] irq_pend, irq_en;
    logic         core_clk_en, periph_clk_en, imask_clr, stack_start, brk_lp_flag, wdog_active;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    lpm_sequencer #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst(rst), .wait_strobe(wait_strobe), .stop_strobe(stop_strobe),
        .irq_pend(irq_pend), .irq_en(irq_en), .break_req(break_req),
        .brk_flag_clr(brk_flag_clr), .wdog_disable(wdog_disable),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .imask_clr(imask_clr),
        .stack_start(stack_start), .brk_lp_flag(brk_lp_flag), .wdog_active(wdog_active)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        wait_strobe = 0; stop_strobe = 0; break_req = 0; brk_flag_clr = 0;
        irq_pend = '0; irq_en = '0;
    endtask

    // enter a low-power state: stop when use_stop=1
    task automatic enter(input bit use_stop, input string req);
        wait_strobe = !use_stop; stop_strobe = use_stop;
        step();
        wait_strobe = 0; stop_strobe = 0;
        chk(req, "imask_clr on entry", imask_clr, 1);
        chk(req, "core_clk_en in low power", core_clk_en, 0);
        chk(use_stop ? "R3" : "R2", "periph_clk_en", periph_clk_en, !use_stop);
    endtask

    task automatic brk_exit();
        break_req = 1;
        step();
        break_req = 0;
        chk("R6", "break wake core", core_clk_en, 1);
        chk("R6", "break flag", brk_lp_flag, 1);
        chk("R6", "no stack on break", stack_start, 0);
        brk_flag_clr = 1;
        step();
        brk_flag_clr = 0;
        chk("R7", "flag cleared by write", brk_lp_flag, 0);
    endtask

    initial begin
        idle_inputs();
        wdog_disable = 0;
        rst = 1;
        step(); step();
        rst = 0;
        // R5 reset values
        chk("R5", "core_clk_en", core_clk_en, 1);
        chk("R5", "periph_clk_en", periph_clk_en, 1);
        chk("R5", "imask_clr", imask_clr, 0);
        chk("R5", "stack_start", stack_start, 0);
        chk("R5", "brk_lp_flag", brk_lp_flag, 0);
        chk("R8", "wdog running", wdog_active, 1);

        // R4 sweep: every enable pattern against every single pending source
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < (1 << N); e++) begin
                for (int s = 0; s < N; s++) begin
                    bit woke;
                    woke = e[s];
                    enter(m[0], "R1");
                    irq_en = e[N-1:0];
                    irq_pend = '0;
                    irq_pend[s] = 1'b1;
                    step();
                    irq_pend = '0; irq_en = '0;
                    chk("R4", "wake on enabled source", core_clk_en, woke);
                    chk("R4", "stack_start pulse", stack_start, woke);
                    chk("R1", "imask_clr single pulse", imask_clr, 0);
                    if (woke) begin
                        step();
                        chk("R4", "stack_start one cycle", stack_start, 0);
                        chk("R4", "periph on after wake", periph_clk_en, 1);
                    end else begin
                        brk_exit();
                    end
                end
            end
        end

        // R1: both strobes -> stop wins
        wait_strobe = 1; stop_strobe = 1;
        step();
        wait_strobe = 0; stop_strobe = 0;
        chk("R1", "stop priority periph", periph_clk_en, 0);
        chk("R8", "wdog off in stop", wdog_active, 0);
        // R9: strobes in stop ignored
        wait_strobe = 1;
        step();
        chk("R9", "no imask pulse", imask_clr, 0);
        chk("R9", "still stop periph", periph_clk_en, 0);
        chk("R9", "still stop core", core_clk_en, 0);
        wait_strobe = 0;
        // R6: break with interrupt same edge
        break_req = 1; irq_en = 4'b0001; irq_pend = 4'b0001;
        step();
        idle_inputs();
        chk("R6", "break+irq no stack", stack_start, 0);
        chk("R6", "break+irq flag", brk_lp_flag, 1);
        chk("R6", "break+irq core on", core_clk_en, 1);

        // R6: break while running does not set flag
        brk_flag_clr = 1; step(); brk_flag_clr = 0;
        chk("R7", "flag cleared", brk_lp_flag, 0);
        break_req = 1; step(); break_req = 0;
        chk("R6", "break in run no flag", brk_lp_flag, 0);

        // R7: set and clear same edge -> set wins
        enter(1'b0, "R1");
        stop_strobe = 1; step(); stop_strobe = 0;
        chk("R9", "stop strobe in wait ignored", periph_clk_en, 1);
        chk("R9", "no imask pulse in wait", imask_clr, 0);
        chk("R8", "wdog in wait", wdog_active, 1);
        wdog_disable = 1; #1;
        chk("R8", "wdog disabled in wait", wdog_active, 0);
        wdog_disable = 0;
        break_req = 1; brk_flag_clr = 1; step(); break_req = 0; brk_flag_clr = 0;
        chk("R7", "set beats clear", brk_lp_flag, 1);
        step();
        chk("R7", "flag sticky", brk_lp_flag, 1);

        // R5: reset from stop clears flag and returns to run
        enter(1'b1, "R1");
        rst = 1; step(); rst = 0;
        chk("R5", "reset exits stop", core_clk_en, 1);
        chk("R5", "reset periph", periph_clk_en, 1);
        chk("R5", "reset clears flag", brk_lp_flag, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule